// File: doc/BRIEF.md
# Update-Broadcast Snooping Line Controller

This block manages one line of a write-back cache on a shared snooping bus. Shared copies stay consistent through update broadcasts rather than invalidation. The block serves processor reads and writes and fetches missing blocks over the bus. It writes dirty victims back before a replacement and broadcasts single-word writes whenever other caches may hold the block. It also watches the commands issued by other caches. When a snooped transaction names the block it holds, it drives the wired-OR shared signal in that same cycle. If it holds the owning copy, it supplies the block.

The line can be in one of five states: empty, exclusive-clean, shared-clean, shared-owned or exclusive-dirty. After every fill and after every update it broadcasts, the controller samples the wired-OR shared input, and that sample decides between the exclusive and shared states. Memory is never written on a write hit. Memory is written only when an owned line is replaced. Bus arbitration, memory and the other caches are outside the block.

Top module: `upd_coh_line`

## Requirements
- R1: After reset the line is empty: snooped commands see no shared signal and no supply, and the first processor access misses.
- R2: A read that hits returns the requested word with `cpu_resp_valid` one cycle after acceptance and issues no bus request.
- R3: A write that hits an exclusive-clean or exclusive-dirty line stores the word, makes the line exclusive-dirty and answers one cycle later with no bus request.
- R4: A write that hits a shared-clean or shared-owned line requests the bus with command 2'b10 (update), carrying tag, word index and data. When granted, the line stores the word and becomes shared-owned if `shared_in` is high, otherwise exclusive-dirty. The response follows one cycle after the grant.
- R5: A read miss requests the bus with command 2'b00 and the new tag. When granted, the line loads `bus_fill_block`, where word i occupies bits [i*WORD_W +: WORD_W]. It becomes shared-clean if `shared_in` is high, otherwise exclusive-clean, and the requested word is returned one cycle later.
- R6: A write miss fetches with command 2'b01. If `shared_in` is high at that grant, an update broadcast (R4) follows. If it is low, the word is stored at once, the line becomes exclusive-dirty and no further transaction occurs.
- R7: A miss that replaces a shared-owned or exclusive-dirty line first issues command 2'b11 (write-back) with the old tag and the full block, then issues the miss command. A clean or empty victim is not written back.
- R8: `shared_out` is high in the same cycle as a snooped read miss, write miss or update whose tag matches a valid line. It stays low for a snooped write-back and for a tag that does not match.
- R9: For a snooped read or write miss that matches a shared-owned or exclusive-dirty line, `snp_supply` is high and `snp_block` carries the block in the same cycle. An exclusive-dirty line then becomes shared-owned and an exclusive-clean line becomes shared-clean.
- R10: A snooped update that matches a valid line replaces the named word and leaves the line shared-clean.
- R11: Snoops take priority: `cpu_req_ready` is low while `snp_valid` is high, and the processor request waits until the next free cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_tag | input | TAG_W | Block tag of the request |
| cpu_req_word | input | IDX_W | Word index within the block |
| cpu_req_wdata | input | WORD_W | Write data |
| cpu_req_ready | output | 1 | Request accepted this cycle when valid |
| cpu_resp_valid | output | 1 | Response strobe |
| cpu_resp_rdata | output | WORD_W | Word read or written |
| bus_req | output | 1 | Bus request, held until granted |
| bus_cmd | output | 2 | 00 read miss, 01 write miss, 10 update, 11 write-back |
| bus_tag | output | TAG_W | Tag of the issued command |
| bus_word | output | IDX_W | Word index of an update |
| bus_wdata | output | WORD_W | Data of an update |
| bus_wb_block | output | WORDS*WORD_W | Block for a write-back |
| bus_gnt | input | 1 | Grant; the transaction completes in this cycle |
| bus_fill_block | input | WORDS*WORD_W | Block delivered on a granted miss |
| shared_in | input | 1 | Sampled wired-OR shared signal |
| snp_valid | input | 1 | Another cache's command on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as `bus_cmd` |
| snp_tag | input | TAG_W | Snooped tag |
| snp_word | input | IDX_W | Snooped update word index |
| snp_wdata | input | WORD_W | Snooped update data |
| shared_out | output | 1 | This cache's contribution to the shared signal |
| snp_supply | output | 1 | This cache supplies the block |
| snp_block | output | WORDS*WORD_W | Supplied block, zero otherwise |

## Verification
The assertions take two things for granted about the environment. A grant arrives only while a request is pending, and a snooped command never shares a cycle with this cache's own grant, because the bus carries one transaction per cycle. The stimulus keeps to both. It raises `bus_gnt` only while the reference model shows a pending request, and it never drives a snoop in the same cycle as a grant. Snoops also arrive only in idle cycles or together with a fresh processor request, so the priority rule is exercised without breaking the one-transaction-per-cycle rule.

// File: rtl/upd_coh_pkg.sv
package upd_coh_pkg;

    typedef enum logic [2:0] {
        LN_NP = 3'd0,
        LN_VE = 3'd1,
        LN_SC = 3'd2,
        LN_SD = 3'd3,
        LN_DY = 3'd4
    } line_st_e;

    typedef enum logic [1:0] {
        BC_RDMISS = 2'b00,
        BC_WRMISS = 2'b01,
        BC_UPDATE = 2'b10,
        BC_WRBACK = 2'b11
    } bus_cmd_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WBACK = 2'd1,
        PH_FILL  = 2'd2,
        PH_BCAST = 2'd3
    } phase_e;

    function automatic logic st_valid(line_st_e s);
        return s != LN_NP;
    endfunction

    function automatic logic st_owned(line_st_e s);
        return (s == LN_SD) || (s == LN_DY);
    endfunction

    function automatic logic st_exclusive(line_st_e s);
        return (s == LN_VE) || (s == LN_DY);
    endfunction

endpackage

// File: rtl/upd_coh_lookup.sv
module upd_coh_lookup
    import upd_coh_pkg::*;
#(
    parameter int TAG_W = 16
) (
    input  logic [TAG_W-1:0] req_tag,
    input  logic [TAG_W-1:0] line_tag,
    input  line_st_e         line_state,
    output logic             hit,
    output logic             owned,
    output logic             exclusive
);
    always_comb begin
        hit       = st_valid(line_state) && (req_tag == line_tag);
        owned     = st_owned(line_state);
        exclusive = st_exclusive(line_state);
    end
endmodule

// File: rtl/upd_coh_snoop.sv
module upd_coh_snoop
    import upd_coh_pkg::*;
#(
    parameter int TAG_W = 16
) (
    input  logic             snp_valid,
    input  logic [1:0]       snp_cmd,
    input  logic [TAG_W-1:0] snp_tag,
    input  logic [TAG_W-1:0] line_tag,
    input  line_st_e         line_state,
    output logic             shared_o,
    output logic             supply_o,
    output logic             absorb_o,
    output logic             st_we_o,
    output line_st_e         st_d
);
    bus_cmd_e cmd;
    logic     match;
    logic     is_miss;

    always_comb begin
        cmd      = bus_cmd_e'(snp_cmd);
        match    = snp_valid && st_valid(line_state) && (snp_tag == line_tag);
        is_miss  = (cmd == BC_RDMISS) || (cmd == BC_WRMISS);
        shared_o = match && (cmd != BC_WRBACK);
        supply_o = match && is_miss && st_owned(line_state);
        absorb_o = match && (cmd == BC_UPDATE);
        st_we_o  = 1'b0;
        st_d     = line_state;
        if (absorb_o) begin
            st_we_o = 1'b1;
            st_d    = LN_SC;
        end else if (match && is_miss) begin
            st_we_o = 1'b1;
            case (line_state)
                LN_DY:   st_d = LN_SD;
                LN_VE:   st_d = LN_SC;
                default: st_d = line_state;
            endcase
        end
    end
endmodule

// File: rtl/upd_coh_ctrl.sv
module upd_coh_ctrl
    import upd_coh_pkg::*;
#(
    parameter  int WORD_W = 32,
    parameter  int WORDS  = 4,
    parameter  int TAG_W  = 16,
    localparam int IDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int BLK_W  = WORD_W * WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [TAG_W-1:0]  cpu_req_tag,
    input  logic [IDX_W-1:0]  cpu_req_word,
    input  logic [WORD_W-1:0] cpu_req_wdata,
    output logic              cpu_req_ready,
    output logic              cpu_resp_valid,
    output logic [WORD_W-1:0] cpu_resp_rdata,
    input  logic              req_hit,
    input  logic              victim_owned,
    input  logic              line_exclusive,
    input  logic              snp_valid,
    input  logic              snp_st_we,
    input  line_st_e          snp_st_d,
    input  logic              snp_absorb,
    input  logic [IDX_W-1:0]  snp_word,
    input  logic [WORD_W-1:0] snp_wdata,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [TAG_W-1:0]  bus_tag,
    output logic [IDX_W-1:0]  bus_word,
    output logic [WORD_W-1:0] bus_wdata,
    input  logic              bus_gnt,
    input  logic [BLK_W-1:0]  bus_fill_block,
    input  logic              shared_in,
    output line_st_e          line_state,
    output logic [TAG_W-1:0]  line_tag,
    output logic [BLK_W-1:0]  line_data
);
    typedef struct packed {
        phase_e                         ph;
        line_st_e                       st;
        logic [TAG_W-1:0]               tag;
        logic [WORDS-1:0][WORD_W-1:0]   data;
        logic                           p_write;
        logic [TAG_W-1:0]               p_tag;
        logic [IDX_W-1:0]               p_word;
        logic [WORD_W-1:0]              p_wdata;
        logic                           resp_v;
        logic [WORD_W-1:0]              resp_d;
    } ctrl_s;

    ctrl_s ctl_q, ctl_d;
    logic  accept;

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.resp_v = 1'b0;
        accept       = 1'b0;
        if (snp_valid) begin
            if (snp_st_we)  ctl_d.st = snp_st_d;
            if (snp_absorb) ctl_d.data[snp_word] = snp_wdata;
        end else if (ctl_q.ph == PH_IDLE) begin
            if (cpu_req_valid) begin
                accept        = 1'b1;
                ctl_d.p_write = cpu_req_write;
                ctl_d.p_tag   = cpu_req_tag;
                ctl_d.p_word  = cpu_req_word;
                ctl_d.p_wdata = cpu_req_wdata;
                if (req_hit) begin
                    if (!cpu_req_write) begin
                        ctl_d.resp_v = 1'b1;
                        ctl_d.resp_d = ctl_q.data[cpu_req_word];
                    end else if (line_exclusive) begin
                        ctl_d.data[cpu_req_word] = cpu_req_wdata;
                        ctl_d.st     = LN_DY;
                        ctl_d.resp_v = 1'b1;
                        ctl_d.resp_d = cpu_req_wdata;
                    end else begin
                        ctl_d.ph = PH_BCAST;
                    end
                end else begin
                    ctl_d.ph = victim_owned ? PH_WBACK : PH_FILL;
                end
            end
        end else if (bus_gnt) begin
            case (ctl_q.ph)
                PH_WBACK: begin
                    ctl_d.st = LN_NP;
                    ctl_d.ph = PH_FILL;
                end
                PH_FILL: begin
                    ctl_d.tag  = ctl_q.p_tag;
                    ctl_d.data = bus_fill_block;
                    if (!ctl_q.p_write) begin
                        ctl_d.st     = shared_in ? LN_SC : LN_VE;
                        ctl_d.resp_v = 1'b1;
                        ctl_d.resp_d = bus_fill_block[ctl_q.p_word*WORD_W +: WORD_W];
                        ctl_d.ph     = PH_IDLE;
                    end else if (shared_in) begin
                        ctl_d.st = LN_SC;
                        ctl_d.ph = PH_BCAST;
                    end else begin
                        ctl_d.data[ctl_q.p_word] = ctl_q.p_wdata;
                        ctl_d.st     = LN_DY;
                        ctl_d.resp_v = 1'b1;
                        ctl_d.resp_d = ctl_q.p_wdata;
                        ctl_d.ph     = PH_IDLE;
                    end
                end
                PH_BCAST: begin
                    ctl_d.data[ctl_q.p_word] = ctl_q.p_wdata;
                    ctl_d.st     = shared_in ? LN_SD : LN_DY;
                    ctl_d.resp_v = 1'b1;
                    ctl_d.resp_d = ctl_q.p_wdata;
                    ctl_d.ph     = PH_IDLE;
                end
                default: ctl_d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        cpu_req_ready  = (ctl_q.ph == PH_IDLE) && !snp_valid;
        cpu_resp_valid = ctl_q.resp_v;
        cpu_resp_rdata = ctl_q.resp_d;
        bus_req        = (ctl_q.ph != PH_IDLE);
        case (ctl_q.ph)
            PH_WBACK: bus_cmd = BC_WRBACK;
            PH_FILL:  bus_cmd = ctl_q.p_write ? BC_WRMISS : BC_RDMISS;
            default:  bus_cmd = BC_UPDATE;
        endcase
        bus_tag    = (ctl_q.ph == PH_WBACK) ? ctl_q.tag : ctl_q.p_tag;
        bus_word   = ctl_q.p_word;
        bus_wdata  = ctl_q.p_wdata;
        line_state = ctl_q.st;
        line_tag   = ctl_q.tag;
        line_data  = ctl_q.data;
    end

    // Environment assumptions: one transaction per bus cycle (R11)
    assert_gnt_has_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_gnt |-> bus_req);
    assert_snoop_gnt_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(snp_valid && bus_gnt));

    assert_wback_only_owned_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_cmd == BC_WRBACK) |-> st_owned(line_state));

    assert_silent_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_hit && cpu_req_write && line_exclusive)
        |=> (!bus_req && cpu_resp_valid && line_state == LN_DY));

    assert_bcast_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_gnt && bus_cmd == BC_UPDATE)
        |=> (cpu_resp_valid && line_state == ($past(shared_in) ? LN_SD : LN_DY)));

    assert_read_fill_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_gnt && bus_cmd == BC_RDMISS)
        |=> (cpu_resp_valid && line_state == ($past(shared_in) ? LN_SC : LN_VE)));

    assert_resp_valid_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_resp_valid |-> st_valid(line_state));
endmodule

// File: rtl/upd_coh_line.sv
module upd_coh_line
    import upd_coh_pkg::*;
#(
    parameter  int WORD_W = 32,
    parameter  int WORDS  = 4,
    parameter  int TAG_W  = 16,
    localparam int IDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int BLK_W  = WORD_W * WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [TAG_W-1:0]  cpu_req_tag,
    input  logic [IDX_W-1:0]  cpu_req_word,
    input  logic [WORD_W-1:0] cpu_req_wdata,
    output logic              cpu_req_ready,
    output logic              cpu_resp_valid,
    output logic [WORD_W-1:0] cpu_resp_rdata,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [TAG_W-1:0]  bus_tag,
    output logic [IDX_W-1:0]  bus_word,
    output logic [WORD_W-1:0] bus_wdata,
    output logic [BLK_W-1:0]  bus_wb_block,
    input  logic              bus_gnt,
    input  logic [BLK_W-1:0]  bus_fill_block,
    input  logic              shared_in,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [TAG_W-1:0]  snp_tag,
    input  logic [IDX_W-1:0]  snp_word,
    input  logic [WORD_W-1:0] snp_wdata,
    output logic              shared_out,
    output logic              snp_supply,
    output logic [BLK_W-1:0]  snp_block
);
    line_st_e           line_state;
    logic [TAG_W-1:0]   line_tag;
    logic [BLK_W-1:0]   line_data;
    logic               req_hit, victim_owned, line_exclusive;
    logic               snp_absorb, snp_st_we;
    line_st_e           snp_st_d;

    upd_coh_lookup #(.TAG_W(TAG_W)) u_lookup (
        .req_tag    (cpu_req_tag),
        .line_tag   (line_tag),
        .line_state (line_state),
        .hit        (req_hit),
        .owned      (victim_owned),
        .exclusive  (line_exclusive)
    );

    upd_coh_snoop #(.TAG_W(TAG_W)) u_snoop (
        .snp_valid  (snp_valid),
        .snp_cmd    (snp_cmd),
        .snp_tag    (snp_tag),
        .line_tag   (line_tag),
        .line_state (line_state),
        .shared_o   (shared_out),
        .supply_o   (snp_supply),
        .absorb_o   (snp_absorb),
        .st_we_o    (snp_st_we),
        .st_d       (snp_st_d)
    );

    upd_coh_ctrl #(.WORD_W(WORD_W), .WORDS(WORDS), .TAG_W(TAG_W)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .cpu_req_valid  (cpu_req_valid),
        .cpu_req_write  (cpu_req_write),
        .cpu_req_tag    (cpu_req_tag),
        .cpu_req_word   (cpu_req_word),
        .cpu_req_wdata  (cpu_req_wdata),
        .cpu_req_ready  (cpu_req_ready),
        .cpu_resp_valid (cpu_resp_valid),
        .cpu_resp_rdata (cpu_resp_rdata),
        .req_hit        (req_hit),
        .victim_owned   (victim_owned),
        .line_exclusive (line_exclusive),
        .snp_valid      (snp_valid),
        .snp_st_we      (snp_st_we),
        .snp_st_d       (snp_st_d),
        .snp_absorb     (snp_absorb),
        .snp_word       (snp_word),
        .snp_wdata      (snp_wdata),
        .bus_req        (bus_req),
        .bus_cmd        (bus_cmd),
        .bus_tag        (bus_tag),
        .bus_word       (bus_word),
        .bus_wdata      (bus_wdata),
        .bus_gnt        (bus_gnt),
        .bus_fill_block (bus_fill_block),
        .shared_in      (shared_in),
        .line_state     (line_state),
        .line_tag       (line_tag),
        .line_data      (line_data)
    );

    assign bus_wb_block = line_data;
    assign snp_block    = snp_supply ? line_data : '0;

    assert_supply_to_shared_R9: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |=> (line_state == LN_SD));

    assert_absorb_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && shared_out && snp_cmd == BC_UPDATE) |=> (line_state == LN_SC));

    assert_snoop_blocks_cpu_R11: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> !cpu_req_ready);

    assert_wback_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_cmd == BC_WRBACK) |-> (!shared_out && !snp_supply));
endmodule

// File: tb/upd_coh_line_test.sv
module upd_coh_line_test;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 32;
    localparam int N  = 4;
    localparam int T  = 16;
    localparam int IW = 2;
    localparam int BW = W * N;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_req_valid = 0, cpu_req_write = 0;
    logic [T-1:0]  cpu_req_tag = '0;
    logic [IW-1:0] cpu_req_word = '0;
    logic [W-1:0]  cpu_req_wdata = '0;
    logic cpu_req_ready, cpu_resp_valid;
    logic [W-1:0] cpu_resp_rdata;
    logic bus_req;
    logic [1:0] bus_cmd;
    logic [T-1:0] bus_tag;
    logic [IW-1:0] bus_word;
    logic [W-1:0] bus_wdata;
    logic [BW-1:0] bus_wb_block;
    logic bus_gnt = 0;
    logic [BW-1:0] bus_fill_block = '0;
    logic shared_in = 0;
    logic snp_valid = 0;
    logic [1:0] snp_cmd = '0;
    logic [T-1:0] snp_tag = '0;
    logic [IW-1:0] snp_word = '0;
    logic [W-1:0] snp_wdata = '0;
    logic shared_out, snp_supply;
    logic [BW-1:0] snp_block;

    always #(CLK_PERIOD/2) clk = ~clk;

    upd_coh_line uut (.*);

    // reference model: states 0 empty, 1 excl-clean, 2 shared-clean, 3 shared-owned, 4 excl-dirty
    int           m_st, m_ph;
    logic [T-1:0] m_tag;
    logic [W-1:0] m_dat [N];
    bit           p_w;
    logic [T-1:0] p_tag;
    int           p_word;
    logic [W-1:0] p_wd;
    bit           m_rv, m_acc, m_done;
    logic [W-1:0] m_rd;
    string        cur_req;
    int           n_chk = 0, n_fail = 0;

    function automatic logic [W-1:0] fillw(logic [T-1:0] tg, int i);
        return {tg, 8'(i), 8'h5a};
    endfunction

    function automatic logic [BW-1:0] fillblk(logic [T-1:0] tg);
        logic [BW-1:0] b;
        for (int i = 0; i < N; i++) b[i*W +: W] = fillw(tg, i);
        return b;
    endfunction

    function automatic logic [BW-1:0] model_blk();
        logic [BW-1:0] b;
        for (int i = 0; i < N; i++) b[i*W +: W] = m_dat[i];
        return b;
    endfunction

    task automatic chk(string what, logic [BW-1:0] act, logic [BW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare_outputs();
        bit hit, sh, sup;
        chk("cpu_req_ready", BW'(cpu_req_ready), BW'(m_ph == 0 && !snp_valid));
        chk("cpu_resp_valid", BW'(cpu_resp_valid), BW'(m_rv));
        if (m_rv) chk("cpu_resp_rdata", BW'(cpu_resp_rdata), BW'(m_rd));
        chk("bus_req", BW'(bus_req), BW'(m_ph != 0));
        if (m_ph != 0) begin
            chk("bus_cmd", BW'(bus_cmd), BW'(m_ph == 1 ? 3 : (m_ph == 2 ? (p_w ? 1 : 0) : 2)));
            chk("bus_tag", BW'(bus_tag), BW'(m_ph == 1 ? m_tag : p_tag));
        end
        if (m_ph == 3) begin
            chk("bus_word", BW'(bus_word), BW'(p_word));
            chk("bus_wdata", BW'(bus_wdata), BW'(p_wd));
        end
        if (m_ph == 1) chk("bus_wb_block", bus_wb_block, model_blk());
        hit = snp_valid && m_st != 0 && snp_tag == m_tag;
        sh  = hit && snp_cmd != 2'b11;
        sup = sh && snp_cmd[1] == 1'b0 && m_st >= 3;
        chk("shared_out", BW'(shared_out), BW'(sh));
        chk("snp_supply", BW'(snp_supply), BW'(sup));
        if (sup) chk("snp_block", snp_block, model_blk());
    endtask

    task automatic model_update();
        bit hit;
        m_rv = 0;
        if (snp_valid) begin
            hit = m_st != 0 && snp_tag == m_tag;
            if (hit && snp_cmd == 2'b10) begin
                m_dat[snp_word] = snp_wdata;
                m_st = 2;
            end else if (hit && snp_cmd[1] == 1'b0) begin
                if (m_st == 4) m_st = 3;
                else if (m_st == 1) m_st = 2;
            end
        end else if (m_ph == 0) begin
            if (cpu_req_valid) begin
                m_acc = 1;
                p_w = cpu_req_write; p_tag = cpu_req_tag;
                p_word = int'(cpu_req_word); p_wd = cpu_req_wdata;
                if (m_st != 0 && cpu_req_tag == m_tag) begin
                    if (!p_w) begin m_rv = 1; m_rd = m_dat[p_word]; end
                    else if (m_st == 1 || m_st == 4) begin
                        m_dat[p_word] = p_wd; m_st = 4; m_rv = 1; m_rd = p_wd;
                    end else m_ph = 3;
                end else m_ph = (m_st >= 3) ? 1 : 2;
            end
        end else if (bus_gnt) begin
            if (m_ph == 1) begin
                m_st = 0; m_ph = 2;
            end else if (m_ph == 2) begin
                m_tag = p_tag;
                for (int i = 0; i < N; i++) m_dat[i] = bus_fill_block[i*W +: W];
                if (!p_w) begin
                    m_st = shared_in ? 2 : 1; m_rv = 1; m_rd = m_dat[p_word]; m_ph = 0;
                end else if (shared_in) begin
                    m_st = 2; m_ph = 3;
                end else begin
                    m_dat[p_word] = p_wd; m_st = 4; m_rv = 1; m_rd = p_wd; m_ph = 0;
                end
            end else begin
                m_dat[p_word] = p_wd; m_st = shared_in ? 3 : 4;
                m_rv = 1; m_rd = p_wd; m_ph = 0;
            end
        end
        if (m_rv) m_done = 1;
    endtask

    task automatic step();
        #1;
        compare_outputs();
        @(posedge clk);
        if (rst_n) model_update();
        @(negedge clk);
    endtask

    task automatic snoop(logic [1:0] cmd, logic [T-1:0] tg, logic [IW-1:0] wd, logic [W-1:0] dat);
        snp_valid = 1; snp_cmd = cmd; snp_tag = tg; snp_word = wd; snp_wdata = dat;
        bus_gnt = 0; cpu_req_valid = 0;
        step();
        snp_valid = 0;
    endtask

    task automatic cpu_op(bit w, logic [T-1:0] tg, logic [IW-1:0] wd, logic [W-1:0] dat,
                          bit sh, int gdelay, bit inj);
        int  waited = 0;
        int  guard  = 0;
        bit  gnt_now;
        m_acc = 0; m_done = 0;
        cpu_req_write = w; cpu_req_tag = tg; cpu_req_word = wd; cpu_req_wdata = dat;
        while (!m_done && guard < 60) begin
            cpu_req_valid = !m_acc;
            snp_valid = inj && guard == 0;
            gnt_now = (m_ph != 0) && !snp_valid && waited >= gdelay;
            bus_gnt = gnt_now;
            shared_in = gnt_now ? sh : 1'b0;
            bus_fill_block = fillblk(tg);
            step();
            if (gnt_now) waited = 0;
            else if (m_ph != 0) waited++;
            guard++;
        end
        if (!m_done) begin
            n_fail++;
            $display("FAIL %s request never completed: actual=0 expected=1", cur_req);
        end
        cpu_req_valid = 0; bus_gnt = 0; shared_in = 0; snp_valid = 0;
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    localparam logic [T-1:0] TA = 16'h00A1, TB_ = 16'h00B2, TC = 16'h00C3,
                             TD = 16'h00D4, TE = 16'h00E5;

    initial begin
        m_st = 0; m_ph = 0; m_rv = 0; m_tag = '0;
        for (int i = 0; i < N; i++) m_dat[i] = '0;
        cur_req = "R1";
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        step();
        snoop(2'b00, 16'h0000, 0, 0);      // R1: empty line, no shared
        snoop(2'b10, TA, 1, 32'h1111);     // R1: update ignored while empty

        cur_req = "R5";
        cpu_op(0, TA, 1, 0, 0, 2, 0);       // read miss, exclusive-clean
        cur_req = "R2";
        cpu_op(0, TA, 2, 0, 0, 0, 0);       // read hit, no bus
        cur_req = "R3";
        cpu_op(1, TA, 0, 32'hDEAD0001, 0, 0, 0);
        cur_req = "R9";
        snoop(2'b00, TA, 0, 0);             // supply, dirty -> shared-owned
        cur_req = "R4";
        cpu_op(1, TA, 3, 32'hBEEF0003, 1, 1, 0);
        cpu_op(1, TA, 1, 32'hBEEF0001, 0, 0, 0);
        cur_req = "R9";
        snoop(2'b01, TA, 0, 0);
        cur_req = "R10";
        snoop(2'b10, TA, 2, 32'hCAFE0002);
        cpu_op(0, TA, 2, 0, 0, 0, 0);
        cur_req = "R8";
        snoop(2'b11, TA, 0, 0);
        snoop(2'b00, TB_, 0, 0);
        cur_req = "R4";
        cpu_op(1, TA, 0, 32'h0BAD0000, 0, 0, 0);
        cur_req = "R7";
        cpu_op(0, TB_, 3, 0, 1, 1, 0);       // write-back then shared fill
        cur_req = "R6";
        cpu_op(1, TC, 1, 32'h5EED0001, 1, 0, 0); // clean victim, shared -> update
        cpu_op(1, TD, 2, 32'h5EED0002, 0, 1, 0); // owned victim, unshared -> dirty
        cur_req = "R9";
        cpu_op(0, TE, 0, 0, 0, 0, 0);
        snoop(2'b01, TE, 0, 0);             // excl-clean -> shared-clean
        cur_req = "R4";
        cpu_op(1, TE, 1, 32'h77770001, 1, 0, 0);
        cur_req = "R11";
        snp_cmd = 2'b00; snp_tag = TE; snp_word = 0; snp_wdata = 0;
        cpu_op(0, TE, 1, 0, 0, 0, 1);
        step();

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule